// File: doc/BRIEF.md
# Banked system-register interface enable register

This block is a 32-bit control register that decides whether a processor reaches its interrupt CPU interface through system-register accesses or through the memory-mapped path. Its enable bit is kept in two copies, one per security state, when the highest privilege level is built in. A single copy is kept otherwise. A security-state select steers each read and write to one copy.

Two more bits disable interrupt bypass, one for each interrupt class. These bits are aliases. Depending on configuration they show the matching bits of the top-level register or of the hypervisor-level register, or they are held in a small local store. Only in one configuration can a write here update the top-level register. That update goes out on write-back outputs in the same cycle. Parameters and enables supplied by the higher privilege levels make fields read as fixed values and drop writes.

Reads are combinational from the stored state and the current side inputs. Writes take effect at the next clock edge. The effective enable of the selected copy is driven on its own output: 1 selects the system-register path, 0 means the memory-mapped path must be used.

Top module: `sysif_enable_reg`

## Requirements
- R1: Bits 31:3 of the read value are always 0, and any value written to them has no effect.
- R2: After reset the stored enable bit of every copy is 0, and the locally stored bypass bits are 0.
- R3: With HAS_TOP_LVL=1 there are two copies of the enable bit, at bit 0. ns_sel=0 selects the secure copy and ns_sel=1 the non-secure copy. A write changes only the selected copy, and the new value reads back from the next cycle on.
- R4: With HAS_TOP_LVL=1 and top_sre_en=0, the enable bit of both copies reads 0 and writes to it are dropped. The stored value shows again once top_sre_en returns to 1.
- R5: With HAS_HYP_LVL=1 and hyp_sre_en=0, the enable bit of the non-secure copy reads 0 and writes to it are dropped. This also applies to the single copy when HAS_TOP_LVL=0.
- R6: With SYSREG_ONLY=1 the enable bit reads 1 and writes to it are dropped.
- R7: With BYPASS_SUPP=0, bits 2:1 both read 1, writes to them are dropped, and byp_wb_en stays 0.
- R8: With BYPASS_SUPP=1, HAS_HYP_LVL=0, HAS_TOP_LVL=1 and sec_disable=0, bits 2:1 read top_byp and are read-only. Bit 2 (IRQ bypass disable) maps to top_byp[1] and bit 1 (FIQ bypass disable) maps to top_byp[0].
- R9: With BYPASS_SUPP=1, HAS_HYP_LVL=0, HAS_TOP_LVL=1 and sec_disable=1, bits 2:1 read top_byp and are writable. In the cycle of a write, byp_wb_en is 1 and byp_wb_data carries written bits {2,1}. In every other case byp_wb_en is 0.
- R10: With BYPASS_SUPP=1 and HAS_HYP_LVL=1, bits 2:1 read hyp_byp (bit 2 from hyp_byp[1]) and are read-only, whatever sec_disable is.
- R11: With HAS_TOP_LVL=1, a write of 0 to bit 0 of the secure copy while that bit reads 1 is dropped. clr_err is then 1 for exactly the one cycle after the write edge, and is 0 at all other times.
- R12: sysreg_en always equals bit 0 of rd_data for the currently selected copy.
- R13: With BYPASS_SUPP=1 and neither a top nor a hypervisor level, bits 2:1 are stored locally, are writable, and read back their last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous warm reset |
| wr_en | input | 1 | Write strobe for the selected copy |
| wr_data | input | 32 | Write value |
| ns_sel | input | 1 | Security state: 0 secure, 1 non-secure |
| top_sre_en | input | 1 | Enable supplied by the highest privilege level |
| hyp_sre_en | input | 1 | Enable supplied by the hypervisor level |
| sec_disable | input | 1 | Security-disable configuration input |
| top_byp | input | 2 | Bypass-disable bits of the top-level register {IRQ, FIQ} |
| hyp_byp | input | 2 | Bypass-disable bits of the hypervisor-level register {IRQ, FIQ} |
| rd_data | output | 32 | Read value of the selected copy |
| sysreg_en | output | 1 | Effective enable: 1 selects the system-register path |
| byp_wb_en | output | 1 | Write-back strobe to the top-level bypass bits |
| byp_wb_data | output | 2 | Write-back value {IRQ, FIQ} |
| clr_err | output | 1 | One-cycle flag for a dropped secure clear |

## Verification
The checker watches several things on every cycle: the reserved bits stay zero, and the forced values from the top-level gate, the hypervisor gate, the system-register-only option and the unsupported-bypass option hold. It also checks that bypass reads follow the right alias source, that write-back is raised only under a write with security disabled, and that every error flag traces back to a secure clear. A blocked secure clear must leave the enable bit set on the next cycle. Other behaviours need the bench's scenarios. These are that a gated copy keeps its stored value until the gate reopens, that a write lands only in the selected copy, that two clears in a row give two flags, and how four differently parameterised instances respond to one shared stimulus stream.

// File: rtl/sysif_pkg.sv
package sysif_pkg;

  localparam int unsigned REG_W    = 32;
  localparam int unsigned EN_POS   = 0;
  localparam int unsigned FBD_POS  = 1;
  localparam int unsigned IBD_POS  = 2;
  localparam int unsigned RSVD_LSB = 3;

  // Where the two bypass-disable bits come from.
  typedef enum logic [2:0] {
    BYP_FORCED_ONE,
    BYP_HYP_RO,
    BYP_TOP_RO,
    BYP_TOP_RW,
    BYP_LOCAL
  } byp_mode_e;

  // Order of precedence: unsupported, hypervisor alias, top alias, local.
  function automatic byp_mode_e pick_byp_mode(input bit supp, input bit has_top,
                                              input bit has_hyp, input logic sec_dis);
    if (!supp)        return BYP_FORCED_ONE;
    else if (has_hyp) return BYP_HYP_RO;
    else if (has_top) return sec_dis ? BYP_TOP_RW : BYP_TOP_RO;
    else              return BYP_LOCAL;
  endfunction

  // A copy is visible only if every applicable higher-level enable is set.
  function automatic logic bank_gate(input bit has_top, input bit has_hyp, input bit is_ns,
                                     input logic top_en, input logic hyp_en);
    return (!has_top || top_en) && (!has_hyp || !is_ns || hyp_en);
  endfunction

  // byp[1] is the IRQ bypass disable, byp[0] the FIQ bypass disable.
  function automatic logic [REG_W-1:0] compose(input logic en, input logic [1:0] byp);
    logic [REG_W-1:0] r;
    r          = '0;
    r[EN_POS]  = en;
    r[FBD_POS] = byp[0];
    r[IBD_POS] = byp[1];
    return r;
  endfunction

endpackage

// File: rtl/sysif_gate.sv
module sysif_gate #(
  parameter int unsigned NBANK       = 2,
  parameter bit          HAS_TOP_LVL = 1'b1,
  parameter bit          HAS_HYP_LVL = 1'b0
) (
  input  logic             top_sre_en,
  input  logic             hyp_sre_en,
  output logic [NBANK-1:0] open_o
);

  // Bank 1 is the non-secure copy; a lone copy is treated as non-secure.
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam bit IS_NS = (NBANK == 1) || (b == 1);
    assign open_o[b] = sysif_pkg::bank_gate(HAS_TOP_LVL, HAS_HYP_LVL, IS_NS,
                                            top_sre_en, hyp_sre_en);
  end

endmodule

// File: rtl/sysif_en_store.sv
module sysif_en_store #(
  parameter int unsigned NBANK           = 2,
  parameter bit          CHECK_SEC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic [NBANK-1:0] bank_sel,
  input  logic [NBANK-1:0] gate_open,
  output logic [NBANK-1:0] rd_en,
  output logic             clr_hit,
  output logic             clr_err
);

  logic [NBANK-1:0] hit;
  logic [NBANK-1:0] take;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam bit SEC = CHECK_SEC_CLEAR && (b == 0);
    logic q;

    assign rd_en[b] = q & gate_open[b];
    // Dropping a secure 1->0 clear keeps the system-register path alive.
    assign hit[b]   = SEC && wr_en && bank_sel[b] && rd_en[b] && !wr_bit;
    assign take[b]  = wr_en && bank_sel[b] && gate_open[b] && !hit[b];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (take[b]) q <= wr_bit;
    end
  end

  assign clr_hit = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_err <= 1'b0;
    else        clr_err <= clr_hit;
  end

endmodule

// File: rtl/sysif_bypass_sel.sv
module sysif_bypass_sel
  import sysif_pkg::*;
#(
  parameter bit HAS_TOP_LVL = 1'b1,
  parameter bit HAS_HYP_LVL = 1'b0,
  parameter bit BYPASS_SUPP = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_byp,
  input  logic       sec_disable,
  input  logic [1:0] top_byp,
  input  logic [1:0] hyp_byp,
  output logic [1:0] rd_byp,
  output logic       wb_en,
  output logic [1:0] wb_data,
  output byp_mode_e  mode
);

  logic [1:0] loc_q;

  assign mode = pick_byp_mode(BYPASS_SUPP, HAS_TOP_LVL, HAS_HYP_LVL, sec_disable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            loc_q <= 2'b00;
    else if (wr_en && mode == BYP_LOCAL)   loc_q <= wr_byp;
  end

  always_comb begin
    case (mode)
      BYP_FORCED_ONE:         rd_byp = 2'b11;
      BYP_HYP_RO:             rd_byp = hyp_byp;
      BYP_TOP_RO, BYP_TOP_RW: rd_byp = top_byp;
      default:                rd_byp = loc_q;
    endcase
  end

  assign wb_en   = wr_en && (mode == BYP_TOP_RW);
  assign wb_data = wr_byp;

endmodule

// File: rtl/sysif_enable_reg.sv
module sysif_enable_reg
  import sysif_pkg::*;
#(
  parameter bit HAS_TOP_LVL = 1'b1,
  parameter bit HAS_HYP_LVL = 1'b0,
  parameter bit SYSREG_ONLY = 1'b0,
  parameter bit BYPASS_SUPP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ns_sel,
  input  logic             top_sre_en,
  input  logic             hyp_sre_en,
  input  logic             sec_disable,
  input  logic [1:0]       top_byp,
  input  logic [1:0]       hyp_byp,
  output logic [REG_W-1:0] rd_data,
  output logic             sysreg_en,
  output logic             byp_wb_en,
  output logic [1:0]       byp_wb_data,
  output logic             clr_err
);

  localparam int unsigned NBANK = HAS_TOP_LVL ? 2 : 1;

  logic [NBANK-1:0] bank_sel;
  logic [NBANK-1:0] gate_open;
  logic [NBANK-1:0] rd_en;
  logic             sel_en;
  logic             clr_hit;
  logic             rsvd_wr;
  logic [1:0]       rd_byp;
  byp_mode_e        byp_mode;

  if (NBANK == 2) begin : g_banked
    assign bank_sel = {ns_sel, ~ns_sel};
    assign sel_en   = ns_sel ? rd_en[1] : rd_en[0];
  end else begin : g_single
    assign bank_sel = 1'b1;
    assign sel_en   = rd_en[0];
  end

  sysif_gate #(
    .NBANK       (NBANK),
    .HAS_TOP_LVL (HAS_TOP_LVL),
    .HAS_HYP_LVL (HAS_HYP_LVL)
  ) u_gate (
    .top_sre_en (top_sre_en),
    .hyp_sre_en (hyp_sre_en),
    .open_o     (gate_open)
  );

  sysif_en_store #(
    .NBANK           (NBANK),
    .CHECK_SEC_CLEAR (HAS_TOP_LVL)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en & ~SYSREG_ONLY),
    .wr_bit    (wr_data[EN_POS]),
    .bank_sel  (bank_sel),
    .gate_open (gate_open),
    .rd_en     (rd_en),
    .clr_hit   (clr_hit),
    .clr_err   (clr_err)
  );

  sysif_bypass_sel #(
    .HAS_TOP_LVL (HAS_TOP_LVL),
    .HAS_HYP_LVL (HAS_HYP_LVL),
    .BYPASS_SUPP (BYPASS_SUPP)
  ) u_byp (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_byp      ({wr_data[IBD_POS], wr_data[FBD_POS]}),
    .sec_disable (sec_disable),
    .top_byp     (top_byp),
    .hyp_byp     (hyp_byp),
    .rd_byp      (rd_byp),
    .wb_en       (byp_wb_en),
    .wb_data     (byp_wb_data),
    .mode        (byp_mode)
  );

  assign sysreg_en = SYSREG_ONLY ? 1'b1 : sel_en;
  assign rd_data   = compose(sysreg_en, rd_byp);
  assign rsvd_wr   = wr_en && (|wr_data[REG_W-1:RSVD_LSB]);

endmodule

// File: rtl/sysif_enable_reg_chk.sv
module sysif_enable_reg_chk
  import sysif_pkg::*;
#(
  parameter bit HAS_TOP_LVL = 1'b1,
  parameter bit HAS_HYP_LVL = 1'b0,
  parameter bit SYSREG_ONLY = 1'b0,
  parameter bit BYPASS_SUPP = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_low,
  input logic             ns_sel,
  input logic             top_sre_en,
  input logic             hyp_sre_en,
  input logic             sec_disable,
  input logic [1:0]       top_byp,
  input logic [1:0]       hyp_byp,
  input logic [REG_W-1:0] rd_data,
  input logic             sysreg_en,
  input logic             byp_wb_en,
  input logic [1:0]       byp_wb_data,
  input logic             clr_err,
  input logic             clr_hit,
  input logic             rsvd_wr,
  input byp_mode_e        byp_mode
);

  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:RSVD_LSB] == '0);

  a_r1_rsvd_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_wr |=> rd_data[REG_W-1:RSVD_LSB] == '0);

  a_r4_top_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_TOP_LVL && !SYSREG_ONLY && !top_sre_en) |-> !sysreg_en);

  a_r5_hyp_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_HYP_LVL && !SYSREG_ONLY && !hyp_sre_en && (ns_sel || !HAS_TOP_LVL)) |-> !sysreg_en);

  a_r6_forced_one: assert property (@(posedge clk) disable iff (!rst_n)
    SYSREG_ONLY |-> rd_data[EN_POS]);

  a_r7_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !BYPASS_SUPP |-> (rd_data[IBD_POS:FBD_POS] == 2'b11 && !byp_wb_en));

  a_r8_top_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_mode == BYP_TOP_RO) |-> (rd_data[IBD_POS:FBD_POS] == top_byp && !byp_wb_en));

  a_r9_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    byp_wb_en |-> (wr_en && sec_disable && byp_wb_data == wr_low[IBD_POS:FBD_POS]));

  a_r10_hyp_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (BYPASS_SUPP && HAS_HYP_LVL) |-> (rd_data[IBD_POS:FBD_POS] == hyp_byp && !byp_wb_en));

  a_r11_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (ns_sel || !top_sre_en || sysreg_en));

  a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |-> $past(wr_en && !ns_sel && !wr_low[EN_POS]));

endmodule

bind sysif_enable_reg sysif_enable_reg_chk #(
  .HAS_TOP_LVL (HAS_TOP_LVL),
  .HAS_HYP_LVL (HAS_HYP_LVL),
  .SYSREG_ONLY (SYSREG_ONLY),
  .BYPASS_SUPP (BYPASS_SUPP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_low      (wr_data[2:0]),
  .ns_sel      (ns_sel),
  .top_sre_en  (top_sre_en),
  .hyp_sre_en  (hyp_sre_en),
  .sec_disable (sec_disable),
  .top_byp     (top_byp),
  .hyp_byp     (hyp_byp),
  .rd_data     (rd_data),
  .sysreg_en   (sysreg_en),
  .byp_wb_en   (byp_wb_en),
  .byp_wb_data (byp_wb_data),
  .clr_err     (clr_err),
  .clr_hit     (clr_hit),
  .rsvd_wr     (rsvd_wr),
  .byp_mode    (byp_mode)
);

// File: tb/sim_sysif_enable_reg.sv
module sim_sysif_enable_reg;

  localparam int NI = 4;
  // Instance configurations, one bit per instance index.
  localparam logic [3:0] C_TOP = 4'b0011;
  localparam logic [3:0] C_HYP = 4'b1010;
  localparam logic [3:0] C_SO  = 4'b0100;
  localparam logic [3:0] C_BYP = 4'b0111;

  // Vector: wr | data[2:0] | ns te he | sec_dis | top_byp | hyp_byp
  localparam int NV = 25;
  localparam logic [11:0] VEC [NV] = '{
    12'b1_001_011_0_01_10, 12'b1_001_111_0_01_10, 12'b0_000_011_0_01_10,
    12'b1_000_011_0_01_10, 12'b0_000_011_0_01_10, 12'b0_000_101_0_01_10,
    12'b1_000_101_0_01_10, 12'b0_000_111_0_01_10, 12'b0_000_110_0_01_10,
    12'b1_110_110_0_01_10, 12'b0_000_111_0_01_10, 12'b1_101_111_1_01_10,
    12'b1_010_011_1_10_01, 12'b0_000_011_0_10_01, 12'b0_000_111_0_11_00,
    12'b1_000_001_0_11_00, 12'b0_000_011_0_00_11, 12'b1_001_011_0_00_11,
    12'b1_000_011_0_00_11, 12'b1_000_011_0_00_11, 12'b0_000_011_0_00_11,
    12'b1_000_111_0_10_10, 12'b0_000_111_0_10_10, 12'b1_011_111_1_01_01,
    12'b0_000_011_1_01_01
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        ns_sel, top_en, hyp_en, sec_dis;
  logic [1:0]  tb_byp, hb_byp;

  logic [31:0] rd  [NI];
  logic        en_o[NI];
  logic        wbe [NI];
  logic [1:0]  wbd [NI];
  logic        er  [NI];

  sysif_enable_reg #(.HAS_TOP_LVL(1'b1), .HAS_HYP_LVL(1'b0), .SYSREG_ONLY(1'b0), .BYPASS_SUPP(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ns_sel(ns_sel),
    .top_sre_en(top_en), .hyp_sre_en(hyp_en), .sec_disable(sec_dis), .top_byp(tb_byp),
    .hyp_byp(hb_byp), .rd_data(rd[0]), .sysreg_en(en_o[0]), .byp_wb_en(wbe[0]),
    .byp_wb_data(wbd[0]), .clr_err(er[0]));
  sysif_enable_reg #(.HAS_TOP_LVL(1'b1), .HAS_HYP_LVL(1'b1), .SYSREG_ONLY(1'b0), .BYPASS_SUPP(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ns_sel(ns_sel),
    .top_sre_en(top_en), .hyp_sre_en(hyp_en), .sec_disable(sec_dis), .top_byp(tb_byp),
    .hyp_byp(hb_byp), .rd_data(rd[1]), .sysreg_en(en_o[1]), .byp_wb_en(wbe[1]),
    .byp_wb_data(wbd[1]), .clr_err(er[1]));
  sysif_enable_reg #(.HAS_TOP_LVL(1'b0), .HAS_HYP_LVL(1'b0), .SYSREG_ONLY(1'b1), .BYPASS_SUPP(1'b1)) u2 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ns_sel(ns_sel),
    .top_sre_en(top_en), .hyp_sre_en(hyp_en), .sec_disable(sec_dis), .top_byp(tb_byp),
    .hyp_byp(hb_byp), .rd_data(rd[2]), .sysreg_en(en_o[2]), .byp_wb_en(wbe[2]),
    .byp_wb_data(wbd[2]), .clr_err(er[2]));
  sysif_enable_reg #(.HAS_TOP_LVL(1'b0), .HAS_HYP_LVL(1'b1), .SYSREG_ONLY(1'b0), .BYPASS_SUPP(1'b0)) u3 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ns_sel(ns_sel),
    .top_sre_en(top_en), .hyp_sre_en(hyp_en), .sec_disable(sec_dis), .top_byp(tb_byp),
    .hyp_byp(hb_byp), .rd_data(rd[3]), .sysreg_en(en_o[3]), .byp_wb_en(wbe[3]),
    .byp_wb_data(wbd[3]), .clr_err(er[3]));

  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;
  logic m_en [NI][2];
  logic [1:0] m_byp [NI];
  logic m_err [NI];

  task automatic check(input string tag, input int c, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s u%0d act=%h exp=%h at %0t", tag, c, act, exp, $time);
    end
  endtask

  function automatic int bank_of(input int c);
    return C_TOP[c] ? int'(ns_sel) : 0;
  endfunction

  function automatic logic gate_ok(input int c);
    logic is_ns;
    is_ns = C_TOP[c] ? ns_sel : 1'b1;
    return (!C_TOP[c] || top_en) && (!C_HYP[c] || !is_ns || hyp_en);
  endfunction

  function automatic logic exp_en(input int c);
    if (C_SO[c]) return 1'b1;
    return gate_ok(c) ? m_en[c][bank_of(c)] : 1'b0;
  endfunction

  function automatic string en_tag(input int c);
    if (C_SO[c])                                         return "R6";
    if (C_TOP[c] && !top_en)                             return "R4";
    if (C_HYP[c] && !hyp_en && (ns_sel || !C_TOP[c]))    return "R5";
    return "R3";
  endfunction

  function automatic logic [1:0] exp_byp(input int c);
    if (!C_BYP[c]) return 2'b11;
    if (C_HYP[c])  return hb_byp;
    if (C_TOP[c])  return tb_byp;
    return m_byp[c];
  endfunction

  function automatic string byp_tag(input int c);
    if (!C_BYP[c]) return "R7";
    if (C_HYP[c])  return "R10";
    if (C_TOP[c])  return sec_dis ? "R9" : "R8";
    return "R13";
  endfunction

  function automatic logic exp_wb(input int c);
    return wr_en && C_BYP[c] && C_TOP[c] && !C_HYP[c] && sec_dis;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NI; c++) begin
      m_en[c][0] = 1'b0;
      m_en[c][1] = 1'b0;
      m_byp[c]   = 2'b00;
      m_err[c]   = 1'b0;
    end
  endtask

  task automatic apply(input logic [11:0] v, input string force_tag);
    @(negedge clk);
    wr_en   = v[11];
    wr_data = {29'h1FFF_FFFF, v[10:8]};
    ns_sel  = v[7];
    top_en  = v[6];
    hyp_en  = v[5];
    sec_dis = v[4];
    tb_byp  = v[3:2];
    hb_byp  = v[1:0];
    #1;
    for (int c = 0; c < NI; c++) begin
      logic cur, hit;
      check("R11", c, 32'(er[c]), 32'(m_err[c]));
      check("R1", c, 32'(rd[c][31:3]), 32'd0);
      check(force_tag != "" ? force_tag : en_tag(c), c, 32'(rd[c][0]), 32'(exp_en(c)));
      check(byp_tag(c), c, 32'(rd[c][2:1]), 32'(exp_byp(c)));
      check("R12", c, 32'(en_o[c]), 32'(exp_en(c)));
      check(C_BYP[c] ? "R9" : "R7", c, 32'(wbe[c]), 32'(exp_wb(c)));
      if (exp_wb(c)) check("R9", c, 32'(wbd[c]), 32'(wr_data[2:1]));
      // Model update for the coming edge.
      cur = exp_en(c);
      hit = C_TOP[c] && !ns_sel && !C_SO[c] && wr_en && cur && !wr_data[0];
      if (wr_en && !C_SO[c] && gate_ok(c) && !hit) m_en[c][bank_of(c)] = wr_data[0];
      if (wr_en && C_BYP[c] && !C_TOP[c] && !C_HYP[c]) m_byp[c] = wr_data[2:1];
      m_err[c] = hit;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; ns_sel = 1'b0;
    top_en = 1'b1; hyp_en = 1'b1; sec_dis = 1'b0; tb_byp = 2'b00; hb_byp = 2'b00;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R2: both copies cleared by reset
    apply(12'b0_000_011_0_00_00, "R2");
    apply(12'b0_000_111_0_00_00, "R2");
    for (int i = 0; i < NV; i++) apply(VEC[i], "");
    apply(12'b0_000_011_0_00_00, "");
    // R2: reset in the middle of a run
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    apply(12'b0_000_011_0_00_00, "R2");
    apply(12'b0_000_111_0_00_00, "R2");
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule